// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a parameterised string of boundary cells that sits between a chip's core logic and its pads. Every cell has two flip-flops. The first flip-flop can take a parallel snapshot of the signal passing through the cell, or act as one stage of a serial shift path that runs from `scan_in` to `scan_out`. The second flip-flop holds the value that the cell drives while test mode is active. The first stage works on the rising test-clock edge. The second stage and the serial output work on the falling edge. Because of this split, the pins stay frozen while new data moves through the first stages, and every driven value changes together when the update strobe fires.

A test controller outside the block supplies a chain-select, three phase strobes (capture, shift, update) and a test-mode select. The first `N_IN` cells after `scan_in` sit on input pads: they see `pin_in` and feed `core_in`. The next `N_OUT` cells sit on output pads: they see `core_out` and feed `pin_out`. When test mode is off, every cell passes its functional signal straight through. A snapshot taken in that state observes the chip without disturbing it, and data shifted in can be parked in the second stages for later use.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_n` is low, both stages of every cell and `scan_out` are 0.
- R2: On a rising `tck` with `sel` and `capture_en` high, first-stage cell i loads `pin_in[i]` for i < N_IN, and cell N_IN+j loads `core_out[j]`. Cell 0 is the cell nearest `scan_in`.
- R3: On a rising `tck` with `sel` and `shift_en` high and `capture_en` low, each first stage i>0 takes the old value of cell i-1, and cell 0 takes `scan_in`. When capture and shift are both high, capture wins.
- R4: After N = N_IN+N_OUT shifts, a word fed into `scan_in` most significant bit first sits in the chain with bit i in cell i. A further N shifts present it on `scan_out` in the same order.
- R5: `scan_out` changes only on a falling `tck` edge, where it takes the first stage of cell N-1.
- R6: On a falling `tck` with `sel` and `update_en` high, every second stage copies its first stage in the same edge.
- R7: Second stages keep their values through capture and shift activity when no update occurs.
- R8: With `test_mode` = 1, `core_in[i]` equals second stage i and `pin_out[j]` equals second stage N_IN+j.
- R9: With `test_mode` = 0, `core_in` equals `pin_in` and `pin_out` equals `core_out`.
- R10: With `sel` low, the capture, shift and update strobes have no effect on either stage.
- R11: A capture taken with `test_mode` = 0 leaves `pin_out` and `core_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Chain selected by the controller |
| capture_en | input | 1 | Capture-phase strobe |
| shift_en | input | 1 | Shift-phase strobe |
| update_en | input | 1 | Update-phase strobe |
| test_mode | input | 1 | 1: cells drive held values; 0: pass-through |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data from cell N-1, falling-edge timed |
| pin_in | input | N_IN | Values arriving from input pads |
| core_in | output | N_IN | Values delivered to the core |
| core_out | input | N_OUT | Values the core wants on output pads |
| pin_out | output | N_OUT | Values driven to output pads |

## Verification
The assertions check on every edge that a capture loads the pad and core values, that a shift moves the chain by one place, that `scan_out` mirrors the last first stage, that second stages and unselected chains hold still, and that the outputs pick the right source for the mode. Some behaviour only the bench scenarios can show. These are: a full round trip of N-bit words through the serial path, capture winning over a simultaneous shift, the exact falling-edge moment when `scan_out` changes, and a sweep over every pad and core pattern of the small configuration.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

  typedef struct packed {
    logic cap;
    logic shf;
    logic upd;
  } strobe_t;

  // Qualify the raw strobes with the chain select; capture outranks shift.
  function automatic strobe_t gate_strobes(logic sel, logic cap, logic shf, logic upd);
    strobe_t s;
    s.cap = sel & cap;
    s.shf = sel & shf & ~cap;
    s.upd = sel & upd;
    return s;
  endfunction

  // Next value of a cell's first stage.
  function automatic logic stage_next(logic cap, logic shf, logic par, logic ser, logic cur);
    logic r;
    if (cap)      r = par;
    else if (shf) r = ser;
    else          r = cur;
    return r;
  endfunction

  // Value a cell presents at its parallel output.
  function automatic logic cell_drive(logic test_mode, logic held, logic func);
    return test_mode ? held : func;
  endfunction

endpackage

// File: rtl/bscan_strobe_gate.sv
`timescale 1ns/1ps
module bscan_strobe_gate
  import bscan_pkg::*;
(
  input  logic sel,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  output logic cap_fire,
  output logic shift_fire,
  output logic upd_fire
);
  strobe_t s;

  always_comb begin
    s          = gate_strobes(sel, capture_en, shift_en, update_en);
    cap_fire   = s.cap;
    shift_fire = s.shf;
    upd_fire   = s.upd;
  end
endmodule

// File: rtl/bscan_cell.sv
`timescale 1ns/1ps
module bscan_cell
  import bscan_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic cap_fire,
  input  logic shift_fire,
  input  logic upd_fire,
  input  logic test_mode,
  input  logic func_in,
  input  logic ser_in,
  output logic ser_out,
  output logic held_out,
  output logic par_out
);
  logic stage_q;
  logic held_q;

  // First stage: capture or shift on the rising edge.
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) stage_q <= 1'b0;
    else        stage_q <= stage_next(cap_fire, shift_fire, func_in, ser_in, stage_q);
  end

  // Second stage: loaded only by the update strobe, on the falling edge.
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)        held_q <= 1'b0;
    else if (upd_fire) held_q <= stage_q;
  end

  assign ser_out  = stage_q;
  assign held_out = held_q;
  assign par_out  = cell_drive(test_mode, held_q, func_in);
endmodule

// File: rtl/bscan_tail.sv
`timescale 1ns/1ps
module bscan_tail (
  input  logic tck,
  input  logic rst_n,
  input  logic last_bit,
  output logic scan_out
);
  // Serial output is retimed to the falling edge so a downstream device
  // sampling on the rising edge sees a settled value.
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) scan_out <= 1'b0;
    else        scan_out <= last_bit;
  end
endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             test_mode,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out
);
  localparam int N = N_IN + N_OUT;

  // Internal events exposed for the checker.
  logic         cap_fire;
  logic         shift_fire;
  logic         upd_fire;
  logic [N-1:0] cap_vec;
  logic [N-1:0] upd_vec;
  logic [N-1:0] func_vec;
  logic [N-1:0] drv_vec;
  logic [N:0]   ser_link;

  assign ser_link[0] = scan_in;
  assign func_vec    = {core_out, pin_in};

  bscan_strobe_gate u_gate (
    .sel        (sel),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .cap_fire   (cap_fire),
    .shift_fire (shift_fire),
    .upd_fire   (upd_fire)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    bscan_cell u_cell (
      .tck        (tck),
      .rst_n      (rst_n),
      .cap_fire   (cap_fire),
      .shift_fire (shift_fire),
      .upd_fire   (upd_fire),
      .test_mode  (test_mode),
      .func_in    (func_vec[i]),
      .ser_in     (ser_link[i]),
      .ser_out    (ser_link[i+1]),
      .held_out   (upd_vec[i]),
      .par_out    (drv_vec[i])
    );
    assign cap_vec[i] = ser_link[i+1];
  end

  assign core_in = drv_vec[N_IN-1:0];
  assign pin_out = drv_vec[N-1:N_IN];

  bscan_tail u_tail (
    .tck      (tck),
    .rst_n    (rst_n),
    .last_bit (ser_link[N]),
    .scan_out (scan_out)
  );
endmodule

// File: rtl/bscan_chain_chk.sv
`timescale 1ns/1ps
module bscan_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input logic                    tck,
  input logic                    rst_n,
  input logic                    sel,
  input logic                    test_mode,
  input logic                    scan_in,
  input logic                    scan_out,
  input logic [N_IN-1:0]         pin_in,
  input logic [N_IN-1:0]         core_in,
  input logic [N_OUT-1:0]        core_out,
  input logic [N_OUT-1:0]        pin_out,
  input logic                    cap_fire,
  input logic                    shift_fire,
  input logic                    upd_fire,
  input logic [N_IN+N_OUT-1:0]   cap_vec,
  input logic [N_IN+N_OUT-1:0]   upd_vec
);
  localparam int N = N_IN + N_OUT;

  assert_capture_load_R2: assert property (@(posedge tck) disable iff (!rst_n)
    cap_fire |=> cap_vec == $past({core_out, pin_in}));

  assert_shift_step_R3: assert property (@(posedge tck) disable iff (!rst_n)
    shift_fire |=> cap_vec == $past({cap_vec[N-2:0], scan_in}));

  assert_serial_tail_R5: assert property (@(posedge tck) disable iff (!rst_n)
    scan_out == cap_vec[N-1]);

  assert_held_stable_R7: assert property (@(posedge tck) disable iff (!rst_n)
    !upd_fire |-> $stable(upd_vec));

  assert_test_drive_R8: assert property (@(posedge tck) disable iff (!rst_n)
    test_mode |-> (pin_out == upd_vec[N-1:N_IN]) && (core_in == upd_vec[N_IN-1:0]));

  assert_transparent_R9: assert property (@(posedge tck) disable iff (!rst_n)
    !test_mode |-> (pin_out == core_out) && (core_in == pin_in));

  assert_idle_hold_R10: assert property (@(posedge tck) disable iff (!rst_n)
    !sel |=> $stable(cap_vec));
endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .tck        (tck),
  .rst_n      (rst_n),
  .sel        (sel),
  .test_mode  (test_mode),
  .scan_in    (scan_in),
  .scan_out   (scan_out),
  .pin_in     (pin_in),
  .core_in    (core_in),
  .core_out   (core_out),
  .pin_out    (pin_out),
  .cap_fire   (cap_fire),
  .shift_fire (shift_fire),
  .upd_fire   (upd_fire),
  .cap_vec    (cap_vec),
  .upd_vec    (upd_vec)
);

// File: tb/test_bscan_chain.sv
`timescale 1ns/1ps
module test_bscan_chain;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int N  = NI + NO;

  logic          tck = 1'b0;
  logic          rst_n = 1'b1;
  logic          sel = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
  logic          test_mode = 1'b0, scan_in = 1'b0;
  logic          scan_out;
  logic [NI-1:0] pin_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out = '0;
  logic [NO-1:0] pin_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 tck = ~tck;  // 50 MHz

  bscan_chain #(.N_IN(NI), .N_OUT(NO)) i_bscan_chain (
    .tck(tck), .rst_n(rst_n), .sel(sel), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .test_mode(test_mode),
    .scan_in(scan_in), .scan_out(scan_out), .pin_in(pin_in),
    .core_in(core_in), .core_out(core_out), .pin_out(pin_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called just after a rising edge. The update strobe acts on the falling
  // edge inside the cycle; capture and shift act on the rising edge ending it.
  task automatic cyc(input logic c, input logic s, input logic u, input logic si);
    capture_en = c; shift_en = s; update_en = u; scan_in = si;
    @(posedge tck); #1;
    capture_en = 0; shift_en = 0; update_en = 0;
  endtask

  task automatic read_bit(output logic b);
    @(negedge tck); #2;
    b = scan_out;
    @(posedge tck); #1;
  endtask

  // Reads the chain (cell N-1 first) while feeding a new word MSB first.
  task automatic xfer(input logic [N-1:0] feed, output logic [N-1:0] got);
    logic b;
    for (int k = 0; k < N; k++) begin
      read_bit(b);
      got[N-1-k] = b;
      cyc(0, 1, 0, feed[N-1-k]);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] got;
    logic [N-1:0] p;
    logic b;
    #3 rst_n = 0;
    test_mode = 1;
    repeat (3) @(posedge tck);
    #1;
    check("R1 scan_out", {31'd0, scan_out}, 0);
    check("R1 pin_out", {28'd0, pin_out}, 0);
    check("R1 core_in", {28'd0, core_in}, 0);
    rst_n = 1;
    test_mode = 0;
    sel = 1;

    // Transparency sweep
    for (int v = 0; v < 256; v++) begin
      pin_in = v[3:0]; core_out = v[7:4];
      #1;
      check("R9 core_in", {28'd0, core_in}, {28'd0, v[3:0]});
      check("R9 pin_out", {28'd0, pin_out}, {28'd0, v[7:4]});
    end
    @(posedge tck); #1;

    // Capture / shift / update sweep over all pad and core patterns
    for (int v = 0; v < 256; v++) begin
      logic [3:0] a, c;
      a = v[3:0]; c = v[7:4];
      p = 8'((v * 37 + 91) & 8'hFF);
      test_mode = 0;
      pin_in = a; core_out = c;
      cyc(1, 0, 0, 0);
      check("R11 pin_out", {28'd0, pin_out}, {28'd0, c});
      check("R11 core_in", {28'd0, core_in}, {28'd0, a});
      xfer(p, got);
      check("R2 captured word", {24'd0, got}, {24'd0, c, a});
      test_mode = 1;
      cyc(0, 0, 1, 0);
      check("R6/R8 pin_out", {28'd0, pin_out}, {28'd0, p[7:4]});
      check("R6/R8 core_in", {28'd0, core_in}, {28'd0, p[3:0]});
      xfer(~p, got);
      check("R4 round trip", {24'd0, got}, {24'd0, p});
      check("R7 pin_out after shift", {28'd0, pin_out}, {28'd0, p[7:4]});
      pin_in = ~a; core_out = ~c;
      cyc(1, 0, 0, 0);
      check("R7 core_in after capture", {28'd0, core_in}, {28'd0, p[3:0]});
      check("R7 pin_out after capture", {28'd0, pin_out}, {28'd0, p[7:4]});
    end

    // R3: capture wins over a simultaneous shift
    test_mode = 0;
    pin_in = 4'h9; core_out = 4'h6;
    cyc(1, 1, 0, 1);
    xfer(8'h3C, got);
    check("R3 capture priority", {24'd0, got}, 32'h69);

    // R10: deselected chain ignores all strobes
    test_mode = 1;
    cyc(0, 0, 1, 0);   // cells now hold 8'h3C, update stage too
    sel = 0;
    pin_in = 4'h5; core_out = 4'hA;
    cyc(1, 0, 1, 1);
    cyc(0, 1, 1, 0);
    cyc(1, 1, 1, 1);
    check("R10 pin_out", {28'd0, pin_out}, 32'h3);
    check("R10 core_in", {28'd0, core_in}, 32'hC);
    sel = 1;
    xfer(8'h40, got);
    check("R10 chain contents", {24'd0, got}, 32'h3C);

    // R5: scan_out moves only at the falling edge (cells hold 8'h40)
    read_bit(b);
    check("R5 settled", {31'd0, b}, 0);
    cyc(0, 1, 0, 0);
    check("R5 before falling edge", {31'd0, scan_out}, 0);
    @(negedge tck); #1;
    check("R5 after falling edge", {31'd0, scan_out}, 1);
    @(posedge tck); #1;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule